// File: doc/BRIEF.md
# Calendar Timekeeper with Match Alarms

This block keeps wall-clock time: seconds, minutes, hours, date, day of week, month and a two-digit year. Its input is a clock enable at 32.768 kHz, which a binary prescaler divides down to one tick per second. The calendar logic knows how long each month is, and it gives February a 29th day in years divisible by four. Every field is held in plain binary.

A host reaches the block through a byte-wide register port with a write strobe and a combinational read. Time values written by the host go into a holding set first. A control write then either loads the whole holding set into the running counters at once, or copies the running counters into the holding set in one cycle, so the host can read them back as a consistent snapshot. The running count is never stalled by either action.

Each of two alarm units holds six compare fields and an enable mask. After each one-second advance, an alarm whose enabled fields all equal the live time sets its own sticky status bit. The host polls that bit and clears it by writing a one to it.

Top module: `rtc_timekeeper`

## Requirements
- R1: The seconds count advances once for every 2^DIV_W cycles in which tick_en_i is high (DIV_W defaults to 15, which gives 32768). Cycles with tick_en_i low neither count nor advance the time.
- R2: Carries ripple as follows. Seconds 0..59 carry into minutes 0..59, which carry into hours 0..23. The hour rollover advances the date and advances the day of week, which runs 0..6 and wraps from 6 to 0. Month runs 1..12, and a December rollover wraps the year from 99 to 0 and sets month and date to 1.
- R3: Months 4, 6, 9 and 11 roll from date 30 to date 1. Months 1, 3, 5, 7, 8, 10 and 12 roll from date 31 to date 1, and the month advances at the same time.
- R4: February rolls over after date 29 when year mod 4 is 0, and after date 28 otherwise.
- R5: A write to address 0..6 (0 sec, 1 min, 2 hour, 3 date, 4 day of week, 5 month, 6 year) stores only into the holding set. Reading the same address returns the holding value, and the running time is not affected.
- R6: Writing address 7 with bit 0 set loads all seven holding fields into the running time on the next edge and clears the prescaler. The next advance then follows 2^DIV_W further enables.
- R7: Writing address 7 with bit 1 set and bit 0 clear copies all running fields into the holding set in that cycle. If an enable or a second advance falls in that same cycle, it is still counted.
- R8: Alarm k (k = 0, 1) has registers at 8+8k+offset: offset 0 sec, 1 min, 2 hour, 3 date, 4 day of week, 5 month, 6 enable mask with bits 0..5 matching those offsets. All of them read back, and the mask reads back as its low 6 bits.
- R9: One cycle after a one-second advance, alarm k sets status bit k at address 24 if its mask is nonzero and every enabled field equals the live time. A zero mask never fires.
- R10: A status bit stays set until a write to address 24 carries a 1 in its position. Writing 0 has no effect. If a set and a clear fall in the same cycle, the set wins. The two alarms are independent.
- R11: After reset the time is 00:00:00, date 1, day of week 0, month 1, year 0. The holding set equals that time, and alarms, masks and status are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | 32.768 kHz clock enable |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |

## Verification
Several properties are checked on every cycle:
- The running time holds still in every cycle that has no second tick and no load.
- The seconds field steps by exactly one on each tick.
- A load copies the holding set.
- February 28 of a non-leap year rolls into March 1.
- A status bit neither appears without an evaluation cycle nor disappears without a clear.

Other behaviour only shows up in the bench's scenarios: the exact enable count per second, month-length and year rollovers, snapshot coherence when a tick lands in the snapshot cycle, and multi-field alarm matches. The bench checks these against a reference model that it builds from the requirements alone.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [4:0] date;
    logic [2:0] dow;
    logic [3:0] month;
    logic [6:0] year;
  } rtc_time_t;

  localparam rtc_time_t TIME_RST = '{sec: 6'd0, min: 6'd0, hour: 5'd0, date: 5'd1,
                                     dow: 3'd0, month: 4'd1, year: 7'd0};

  function automatic logic [4:0] month_days(logic [3:0] m, logic [6:0] y);
    case (m)
      4'd2:                        return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:     return 5'd30;
      default:                     return 5'd31;
    endcase
  endfunction

  function automatic rtc_time_t step_second(rtc_time_t t);
    rtc_time_t n;
    n = t;
    if (t.sec < 6'd59) n.sec = t.sec + 6'd1;
    else begin
      n.sec = 6'd0;
      if (t.min < 6'd59) n.min = t.min + 6'd1;
      else begin
        n.min = 6'd0;
        if (t.hour < 5'd23) n.hour = t.hour + 5'd1;
        else begin
          n.hour = 5'd0;
          n.dow  = (t.dow >= 3'd6) ? 3'd0 : t.dow + 3'd1;
          if (t.date < month_days(t.month, t.year)) n.date = t.date + 5'd1;
          else begin
            n.date = 5'd1;
            if (t.month < 4'd12) n.month = t.month + 4'd1;
            else begin
              n.month = 4'd1;
              n.year  = (t.year >= 7'd99) ? 7'd0 : t.year + 7'd1;
            end
          end
        end
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  // tick on wrap from all-ones to zero
  assign tick_o = en_i && !clr_i && (cnt_q == '1);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      load_i,
  input  rtc_time_t load_val_i,
  output rtc_time_t now_o
);
  rtc_time_t now_q, nxt;

  always_comb nxt = step_second(now_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     now_q <= TIME_RST;
    else if (load_i) now_q <= load_val_i;
    else if (tick_i) now_q <= nxt;
  end

  assign now_o = now_q;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [2:0]        ofs_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [5:0]        sec_i,
  input  logic [5:0]        min_i,
  input  logic [4:0]        hour_i,
  input  logic [4:0]        date_i,
  input  logic [2:0]        dow_i,
  input  logic [3:0]        month_i,
  output logic [DATA_W-1:0] rd_o,
  output logic              match_o
);
  localparam int NF = 6;

  logic [DATA_W-1:0] fld_q [NF];
  logic [DATA_W-1:0] cur   [NF];
  logic [NF-1:0]     mask_q;
  logic [NF-1:0]     eq;

  assign cur[0] = DATA_W'(sec_i);
  assign cur[1] = DATA_W'(min_i);
  assign cur[2] = DATA_W'(hour_i);
  assign cur[3] = DATA_W'(date_i);
  assign cur[4] = DATA_W'(dow_i);
  assign cur[5] = DATA_W'(month_i);

  for (genvar f = 0; f < NF; f++) begin : g_fld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               fld_q[f] <= '0;
      else if (wr_i && ofs_i == 3'(f))           fld_q[f] <= wdata_i;
    end
    assign eq[f] = !mask_q[f] || (fld_q[f] == cur[f]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          mask_q <= '0;
    else if (wr_i && ofs_i == 3'(NF))     mask_q <= wdata_i[NF-1:0];
  end

  assign match_o = (|mask_q) && (&eq);

  always_comb begin
    rd_o = '0;
    for (int f = 0; f < NF; f++)
      if (ofs_i == 3'(f)) rd_o = fld_q[f];
    if (ofs_i == 3'(NF)) rd_o = DATA_W'(mask_q);
  end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int DIV_W      = 15,
  parameter int NUM_ALARMS = 2,
  parameter int ADDR_W     = $clog2((NUM_ALARMS + 2) * 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PG_W    = ADDR_W - 3;
  localparam int STAT_PG = NUM_ALARMS + 1;

  logic [PG_W-1:0]       page;
  logic [2:0]            ofs;
  logic                  wr_time, wr_ctrl, do_load, do_snap, sec_tick, eval_q;
  logic [NUM_ALARMS-1:0] clr_bits, hit, status_q;
  logic [DATA_W-1:0]     alarm_rd [NUM_ALARMS];
  rtc_time_t             live, hold_q;

  assign page     = addr_i[ADDR_W-1:3];
  assign ofs      = addr_i[2:0];
  assign wr_time  = wr_i && (page == '0) && (ofs != 3'd7);
  assign wr_ctrl  = wr_i && (page == '0) && (ofs == 3'd7);
  assign do_load  = wr_ctrl && wdata_i[0];
  assign do_snap  = wr_ctrl && wdata_i[1] && !wdata_i[0];
  assign clr_bits = (wr_i && page == PG_W'(STAT_PG) && ofs == 3'd0) ?
                    wdata_i[NUM_ALARMS-1:0] : '0;

  rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(tick_en_i), .clr_i(do_load), .tick_o(sec_tick)
  );

  rtc_calendar u_cal (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(sec_tick), .load_i(do_load),
    .load_val_i(hold_q), .now_o(live)
  );

  // holding set: host writes and coherent snapshot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= TIME_RST;
    else if (do_snap) hold_q <= live;
    else if (wr_time) begin
      case (ofs)
        3'd0:    hold_q.sec   <= wdata_i[5:0];
        3'd1:    hold_q.min   <= wdata_i[5:0];
        3'd2:    hold_q.hour  <= wdata_i[4:0];
        3'd3:    hold_q.date  <= wdata_i[4:0];
        3'd4:    hold_q.dow   <= wdata_i[2:0];
        3'd5:    hold_q.month <= wdata_i[3:0];
        default: hold_q.year  <= wdata_i[6:0];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eval_q <= 1'b0;
    else         eval_q <= sec_tick;
  end

  for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_alarm
    rtc_alarm #(.DATA_W(DATA_W)) u_alarm (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_i(wr_i && page == PG_W'(k + 1)), .ofs_i(ofs), .wdata_i(wdata_i),
      .sec_i(live.sec), .min_i(live.min), .hour_i(live.hour), .date_i(live.date),
      .dow_i(live.dow), .month_i(live.month),
      .rd_o(alarm_rd[k]), .match_o(hit[k])
    );

    // set wins over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 status_q[k] <= 1'b0;
      else if (eval_q && hit[k])   status_q[k] <= 1'b1;
      else if (clr_bits[k])        status_q[k] <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (page == '0) begin
      case (ofs)
        3'd0:    rdata_o = DATA_W'(hold_q.sec);
        3'd1:    rdata_o = DATA_W'(hold_q.min);
        3'd2:    rdata_o = DATA_W'(hold_q.hour);
        3'd3:    rdata_o = DATA_W'(hold_q.date);
        3'd4:    rdata_o = DATA_W'(hold_q.dow);
        3'd5:    rdata_o = DATA_W'(hold_q.month);
        3'd6:    rdata_o = DATA_W'(hold_q.year);
        default: rdata_o = '0;
      endcase
    end else if (page == PG_W'(STAT_PG)) begin
      if (ofs == 3'd0) rdata_o = DATA_W'(status_q);
    end else begin
      for (int k = 0; k < NUM_ALARMS; k++)
        if (page == PG_W'(k + 1)) rdata_o = alarm_rd[k];
    end
  end
endmodule

// File: rtl/rtc_timekeeper_chk.sv
module rtc_timekeeper_chk
  import rtc_pkg::*;
#(
  parameter int NUM_ALARMS = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  tick,
  input logic                  load,
  input rtc_time_t             hold,
  input rtc_time_t             live,
  input logic [NUM_ALARMS-1:0] status,
  input logic                  eval,
  input logic [NUM_ALARMS-1:0] clr
);
  p_stable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !load) |=> $stable(live));

  p_sec_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !load) |=> (live.sec == (($past(live.sec) == 6'd59) ? 6'd0 : $past(live.sec) + 6'd1)));

  p_feb_plain_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !load && live.month == 4'd2 && live.date == 5'd28 && live.hour == 5'd23 &&
     live.min == 6'd59 && live.sec == 6'd59 && live.year[1:0] != 2'b00)
    |=> (live.month == 4'd3 && live.date == 5'd1));

  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (live == $past(hold)));

  for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_st
    p_no_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!eval && !status[k]) |=> !status[k]);
    p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status[k] && !clr[k]) |=> status[k]);
  end
endmodule

bind rtc_timekeeper rtc_timekeeper_chk #(.NUM_ALARMS(NUM_ALARMS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick(sec_tick), .load(do_load), .hold(hold_q),
  .live(live), .status(status_q), .eval(eval_q), .clr(clr_bits)
);

// File: tb/sim_rtc_timekeeper.sv
module sim_rtc_timekeeper;
  localparam int DIVW = 4;
  localparam int PER  = 1 << DIVW;
  localparam int STAT = 24;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_en_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;

  always #4 clk = ~clk;

  rtc_timekeeper #(.DIV_W(DIVW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_en_i(tick_en_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  int n_chk = 0, n_bad = 0;
  int lm[7] = '{0, 0, 0, 1, 0, 1, 0};
  int hm[7] = '{0, 0, 0, 1, 0, 1, 0};
  int al[2][7];
  int cnt_m = 0;
  bit [1:0] st_m = '0;
  bit pend = 1'b0;
  int r;

  function automatic int dim(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic void adv();
    lm[0]++;
    if (lm[0] < 60) return;
    lm[0] = 0; lm[1]++;
    if (lm[1] < 60) return;
    lm[1] = 0; lm[2]++;
    if (lm[2] < 24) return;
    lm[2] = 0;
    lm[4] = (lm[4] + 1) % 7;
    lm[3]++;
    if (lm[3] <= dim(lm[5], lm[6])) return;
    lm[3] = 1; lm[5]++;
    if (lm[5] <= 12) return;
    lm[5] = 1;
    lm[6] = (lm[6] + 1) % 100;
  endfunction

  function automatic bit hitm(int k);
    if (al[k][6] == 0) return 1'b0;
    for (int f = 0; f < 6; f++)
      if (al[k][6][f] && al[k][f] != lm[f]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(bit w, int a, int d, bit e, output int rd);
    bit [1:0] hits, clr;
    bit ld, sn, tk;
    int old[7];
    @(negedge clk);
    wr_i = w; addr_i = a[4:0]; wdata_i = d[7:0]; tick_en_i = e;
    #1 rd = int'(rdata_o);
    hits = '0;
    if (pend) for (int k = 0; k < 2; k++) hits[k] = hitm(k);
    clr = (w && a == STAT) ? d[1:0] : 2'b00;
    st_m = (st_m & ~clr) | hits;
    ld = w && a == 7 && d[0];
    sn = w && a == 7 && d[1] && !d[0];
    old = lm;
    tk = 1'b0;
    if (ld) begin lm = hm; cnt_m = 0; end
    else if (e) begin
      if (cnt_m == PER - 1) begin cnt_m = 0; tk = 1'b1; adv(); end
      else cnt_m++;
    end
    if (sn) hm = old;
    else if (w && a < 7) hm[a] = d;
    if (w && a >= 8 && a <= 14)  al[0][a-8]  = (a == 14) ? (d & 63) : d;
    if (w && a >= 16 && a <= 22) al[1][a-16] = (a == 22) ? (d & 63) : d;
    pend = tk;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 31, 0, 0, r);
  endtask

  task automatic run_en(int n, bit rnd);
    for (int i = 0; i < n; i++) cyc(0, 31, 0, rnd ? ($urandom % 4 != 0) : 1'b1, r);
    idle(1);
  endtask

  task automatic set_time(input int t[7]);
    for (int f = 0; f < 7; f++) cyc(1, f, t[f], 0, r);
    cyc(1, 7, 1, 0, r);
  endtask

  task automatic check_time(string tag, bit en_snap);
    cyc(1, 7, 2, en_snap, r);
    for (int f = 0; f < 7; f++) begin
      cyc(0, f, 0, 0, r);
      chk($sformatf("%s field %0d", tag, f), r, hm[f]);
    end
  endtask

  task automatic check_status(string tag);
    idle(1);
    cyc(0, STAT, 0, 0, r);
    chk(tag, r, st_m);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R11 reset values
    for (int f = 0; f < 7; f++) begin
      cyc(0, f, 0, 0, r);
      chk("R11 reset hold", r, (f == 3 || f == 5) ? 1 : 0);
    end
    cyc(0, STAT, 0, 0, r); chk("R11 reset status", r, 0);
    cyc(0, 14, 0, 0, r);   chk("R11 reset mask", r, 0);

    // R5 hold write does not touch live time
    cyc(1, 0, 30, 0, r);
    cyc(0, 0, 0, 0, r);    chk("R5 hold readback", r, 30);
    run_en(PER, 0);
    check_time("R5 live untouched", 0);
    chk("R5 sec literal", hm[0], 1);

    // R1 exact enable count, R6 load clears prescaler
    run_en(7, 0);
    set_time('{10, 20, 3, 5, 2, 7, 21});
    run_en(PER - 1, 0);
    check_time("R6 no early tick", 0);
    chk("R1 sec before", hm[0], 10);
    run_en(1, 0);
    check_time("R1 one tick", 0);
    chk("R1 sec after", hm[0], 11);
    run_en(5 * PER, 1);
    check_time("R1 gapped enables", 0);

    // R7 tick lands in snapshot cycle
    set_time('{40, 0, 0, 1, 0, 1, 0});
    run_en(PER - 1, 0);
    check_time("R7 snap with tick", 1);
    chk("R7 old sec", hm[0], 40);
    check_time("R7 tick kept", 0);
    chk("R7 new sec", hm[0], 41);

    // R2 carries and wraps
    set_time('{59, 59, 23, 15, 6, 6, 10});
    run_en(PER, 0); check_time("R2 day carry", 0);
    chk("R2 dow wrap", hm[4], 0);
    set_time('{59, 59, 23, 31, 3, 12, 99});
    run_en(PER, 0); check_time("R2 year wrap", 0);
    chk("R2 year literal", hm[6], 0);

    // R3 month lengths
    set_time('{59, 59, 23, 30, 1, 4, 5});
    run_en(PER, 0); check_time("R3 april", 0);
    chk("R3 may", hm[5], 5);
    set_time('{59, 59, 23, 30, 1, 1, 5});
    run_en(PER, 0); check_time("R3 jan 30", 0);
    chk("R3 jan 31", hm[3], 31);
    set_time('{59, 59, 23, 30, 1, 9, 5});
    run_en(PER, 0); check_time("R3 september", 0);

    // R4 february
    set_time('{59, 59, 23, 28, 1, 2, 3});
    run_en(PER, 0); check_time("R4 plain feb", 0);
    chk("R4 march", hm[5], 3);
    set_time('{59, 59, 23, 28, 1, 2, 4});
    run_en(PER, 0); check_time("R4 leap 28", 0);
    chk("R4 feb 29", hm[3], 29);
    set_time('{59, 59, 23, 29, 1, 2, 0});
    run_en(PER, 0); check_time("R4 leap 29", 0);
    chk("R4 mar 1", hm[3], 1);

    // R8 alarm registers and match
    cyc(1, 8, 3, 0, r);  cyc(1, 14, 8'hC1, 0, r);
    cyc(1, 17, 1, 0, r); cyc(1, 18, 0, 0, r); cyc(1, 22, 6, 0, r);
    cyc(0, 8, 0, 0, r);  chk("R8 alarm0 sec readback", r, 3);
    cyc(0, 14, 0, 0, r); chk("R8 mask low bits", r, 1);
    cyc(0, 22, 0, 0, r); chk("R8 alarm1 mask", r, 6);
    set_time('{0, 0, 0, 1, 0, 1, 0});
    run_en(2 * PER, 0); check_status("R9 no early fire");
    run_en(PER, 0);     check_status("R9 alarm0 fires");
    chk("R9 literal", st_m, 1);
    cyc(1, STAT, 0, 0, r); check_status("R10 write 0 no effect");
    run_en(PER, 0); check_status("R10 sticky");
    cyc(1, STAT, 1, 0, r); check_status("R10 cleared");
    chk("R10 clear literal", st_m, 0);
    set_time('{58, 0, 0, 1, 0, 1, 0});
    run_en(2 * PER, 0); check_status("R10 alarm1 alone");
    chk("R10 independent", st_m, 2);
    cyc(1, STAT, 3, 0, r);
    cyc(1, 14, 0, 0, r);
    set_time('{2, 0, 0, 1, 0, 1, 0});
    run_en(PER, 0); check_status("R9 zero mask silent");

    // random sweep, R2 with alarm model
    for (int it = 0; it < 40; it++) begin
      int t[7];
      t[6] = $urandom % 100; t[5] = 1 + $urandom % 12;
      t[3] = 1 + $urandom % dim(t[5], t[6]); t[4] = $urandom % 7;
      t[2] = $urandom % 24; t[1] = $urandom % 60; t[0] = $urandom % 60;
      if (it % 4 == 0) begin
        cyc(1, 8 + ($urandom % 6), $urandom % 60, 0, r);
        cyc(1, 14, 1 << ($urandom % 2), 0, r);
      end
      set_time(t);
      run_en(PER * (1 + $urandom % 70), 1);
      check_time("R2 random", $urandom % 2);
      check_status("R9 random status");
      cyc(1, STAT, 3, 0, r);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule